// File: doc/BRIEF.md
# Fifth-Order Sinc Decimation Filter

This block converts the one-bit output stream of a delta-sigma modulator into 24-bit signed conversion results. The system clock is divided by six to form the modulator sampling point; at that point one modulator bit enters a chain of five cascaded integrators. After every 64 samples the final integrator is decimated into a chain of five comb (differencing) stages. The comb output carries a gain of 2^30. It is scaled down to 24 bits, clamped to the signed range, and presented together with a one-cycle result strobe.

A synchronous restart input wipes all filter history and restarts the sample phase. The filter needs five conversions to fill its 320-sample window after a restart. A settled flag tells the consumer when that window is full and the results are no longer partial. The modulator, serial read-out and input multiplexing sit outside this block.

Top module: `sinc5_decimator`

## Requirements
- R1: While reset is asserted and right after its release, `result` is 0, `result_valid` is 0 and `settled` is 0.
- R2: One modulator bit is taken every 6 clocks; the first is taken on the 6th rising edge after reset release or after a restart edge. `result_valid` is a single-cycle pulse that repeats every 384 clocks.
- R3: A sample bit of 1 counts as +1 and a bit of 0 counts as -1, and samples from before the last restart count as 0. Let y be the sum over the newest 320 samples, each weighted by its coefficient in the polynomial (1 + z^-1 + ... + z^-63)^5, with the newest sample taking the z^0 weight. On the strobe that follows the 64th, 128th, ... sample, `result` equals y divided by 128 and rounded toward minus infinity.
- R4: When y/128 exceeds 7FFFFF hex, as it does for a stream of all ones, `result` saturates at 7FFFFF hex and does not wrap.
- R5: A stream of all zeros settles at negative full scale, 800000 hex.
- R6: `settled` is low until the fifth strobe after reset or restart. It rises in the same cycle as that strobe and stays high until the next restart.
- R7: A restart zeroes `result`, drops `result_valid` and `settled`, and clears all history. Results after a restart are identical to results after a fresh reset.
- R8: If restart is asserted on the edge that would produce a strobe, the restart wins: no strobe appears and the pending result is discarded.
- R9: `result` holds its value between strobes, except when a restart zeroes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous clear of filter state and sample phase |
| mod_bit | input | 1 | Modulator output bit |
| result | output | 24 | Signed conversion result, saturated |
| result_valid | output | 1 | One-cycle strobe marking a new result |
| settled | output | 1 | High once the filter window is full |

## Verification
A restart and the decimation edge can land on the same clock edge. At that moment the comb chain is about to load a new result while every register is also told to clear. The bench feeds 63 samples, holds the 64th, and asserts restart for exactly the sixth clock of that sample. It then expects no strobe, a zero result and a low settled flag. The scoreboard is then reset to an empty history and must match the following conversions exactly, which shows that no trace of the discarded result survives.

// File: rtl/sinc5_decimator.sv
module sinc5_decimator #(
  parameter int CLK_DIV = 6,
  parameter int RATIO   = 64,
  parameter int ORDER   = 5,
  parameter int OUT_W   = 24,
  parameter int SETTLE  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             mod_bit,
  output logic [OUT_W-1:0] result,
  output logic             result_valid,
  output logic             settled
);

  localparam int DIV_W = $clog2(CLK_DIV);
  localparam int DEC_W = $clog2(RATIO);
  localparam int SET_W = $clog2(SETTLE + 1);
  localparam int ACC_W = ORDER * DEC_W + 2;
  localparam int SHIFT = ACC_W - 1 - OUT_W;
  localparam logic signed [ACC_W-1:0] SAT_HI = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic [DIV_W-1:0] div_q;
  logic [DEC_W-1:0] dec_q;
  logic [SET_W-1:0] res_cnt;
  logic             smp_en, dump;

  logic signed [ACC_W-1:0] integ     [ORDER];
  logic signed [ACC_W-1:0] integ_nxt [ORDER];
  logic signed [ACC_W-1:0] dly       [ORDER];
  logic signed [ACC_W-1:0] comb_out  [ORDER];
  logic signed [ACC_W-1:0] scaled;
  logic        [OUT_W-1:0] sat_val;

  assign smp_en  = (div_q == DIV_W'(CLK_DIV - 1));
  assign dump    = smp_en && (dec_q == DEC_W'(RATIO - 1));
  assign settled = (res_cnt == SET_W'(SETTLE));

  always_comb begin
    integ_nxt[0] = integ[0] + {{(ACC_W-1){~mod_bit}}, 1'b1};
    for (int k = 1; k < ORDER; k++)
      integ_nxt[k] = integ[k] + integ_nxt[k-1];
    comb_out[0] = integ_nxt[ORDER-1] - dly[0];
    for (int k = 1; k < ORDER; k++)
      comb_out[k] = comb_out[k-1] - dly[k];
  end

  assign scaled = comb_out[ORDER-1] >>> SHIFT;

  always_comb begin
    if (scaled > SAT_HI)      sat_val = SAT_HI[OUT_W-1:0];
    else if (scaled < SAT_LO) sat_val = SAT_LO[OUT_W-1:0];
    else                      sat_val = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q        <= '0;
      dec_q        <= '0;
      res_cnt      <= '0;
      result       <= '0;
      result_valid <= 1'b0;
      for (int k = 0; k < ORDER; k++) begin
        integ[k] <= '0;
        dly[k]   <= '0;
      end
    end else if (restart) begin
      div_q        <= '0;
      dec_q        <= '0;
      res_cnt      <= '0;
      result       <= '0;
      result_valid <= 1'b0;
      for (int k = 0; k < ORDER; k++) begin
        integ[k] <= '0;
        dly[k]   <= '0;
      end
    end else begin
      div_q        <= smp_en ? '0 : div_q + 1'b1;
      result_valid <= dump;
      if (smp_en) begin
        dec_q <= dec_q + 1'b1;
        for (int k = 0; k < ORDER; k++)
          integ[k] <= integ_nxt[k];
      end
      if (dump) begin
        result <= sat_val;
        dly[0] <= integ_nxt[ORDER-1];
        for (int k = 1; k < ORDER; k++)
          dly[k] <= comb_out[k-1];
        if (!settled)
          res_cnt <= res_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sinc5_decimator_chk.sv
module sinc5_decimator_chk #(
  parameter int OUT_W = 24,
  parameter int GAP   = 384
) (
  input logic             clk,
  input logic             rst_n,
  input logic             restart,
  input logic [OUT_W-1:0] result,
  input logic             result_valid,
  input logic             settled
);

  logic [15:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_q <= '0;
    else if (restart)          gap_q <= '0;
    else if (result_valid)     gap_q <= 16'd1;
    else if (gap_q != 16'hFFFF) gap_q <= gap_q + 16'd1;
  end

  // R2
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> gap_q == 16'(GAP));

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R6
  settled_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !restart) |=> settled);

  // R6
  settled_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled) |-> result_valid);

  // R7
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!result_valid && !settled && result == '0));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> (result_valid || $past(restart)));

endmodule

bind sinc5_decimator sinc5_decimator_chk #(.OUT_W(OUT_W), .GAP(CLK_DIV * RATIO)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .restart      (restart),
  .result       (result),
  .result_valid (result_valid),
  .settled      (settled)
);

// File: tb/sinc5_decimator_test.sv
module sinc5_decimator_test;

  localparam int TAPS = 320;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic        mod_bit = 1'b0;
  logic [23:0] result;
  logic        result_valid;
  logic        settled;

  always #4 clk = ~clk;

  sinc5_decimator uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (restart),
    .mod_bit      (mod_bit),
    .result       (result),
    .result_valid (result_valid),
    .settled      (settled)
  );

  int          n_chk = 0, n_bad = 0;
  bit          done = 0;
  longint      h [TAPS];
  int          hist [TAPS];
  int          nsamp = 0, nres = 0;
  logic [23:0] q_val [$];
  bit          q_set [$];
  string       q_tag [$];
  logic [23:0] held = '0;
  longint      cyc = 0, last_v = -1;

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] expect_word();
    longint y = 0;
    longint s;
    for (int k = 0; k < TAPS; k++) y += h[k] * hist[k];
    s = y >>> 7;
    if (s > 64'sd8388607)  s = 64'sd8388607;
    if (s < -64'sd8388608) s = -64'sd8388608;
    return s[23:0];
  endfunction

  task automatic clear_model();
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    nsamp = 0; nres = 0; held = '0; last_v = -1;
    q_val.delete(); q_set.delete(); q_tag.delete();
  endtask

  // starts at a negedge after a sampling or clearing edge
  task automatic send(bit b, string tag);
    mod_bit = b;
    repeat (6) @(posedge clk);
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = b ? 1 : -1;
    nsamp++;
    if (nsamp % 64 == 0) begin
      nres++;
      q_val.push_back(expect_word());
      q_set.push_back(nres >= 5);
      q_tag.push_back(tag);
    end
    @(negedge clk);
  endtask

  task automatic do_restart();
    restart = 1'b1;
    @(posedge clk);
    clear_model();
    @(negedge clk);
    restart = 1'b0;
    check(result_valid == 1'b0 && settled == 1'b0 && result == '0, "R7",
          {result_valid, settled, result}, 0);
  endtask

  task automatic run(int mode, int nconv, string tag);
    for (int i = 0; i < nconv * 64; i++) begin
      case (mode)
        0: send(1'b1, tag);
        1: send(1'b0, tag);
        2: send(1'($urandom), tag);
        default: send(1'(i), tag);
      endcase
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops and compares, mid-cycle
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (result_valid) begin
        if (q_val.size() == 0) begin
          check(0, "R2 unexpected strobe", result, 0);
        end else begin
          logic [23:0] ev;
          bit es;
          string et;
          ev = q_val.pop_front(); es = q_set.pop_front(); et = q_tag.pop_front();
          check(result == ev, et, result, ev);
          check(settled == es, "R6", settled, es);
          if (last_v >= 0) check(cyc - last_v == 384, "R2 spacing", cyc - last_v, 384);
        end
        last_v = cyc;
        held = result;
      end else begin
        check(result == held, "R9", result, held);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(result == '0 && result_valid == 1'b0 && settled == 1'b0, "R1",
          {result_valid, settled, result}, 0);
    clear_model();
    rst_n = 1'b1;
    check(result == '0 && result_valid == 1'b0 && settled == 1'b0, "R1",
          {result_valid, settled, result}, 0);

    run(0, 6, "R4");
    check(result == 24'h7FFFFF, "R4 final", result, 24'h7FFFFF);

    do_restart();
    run(1, 6, "R5");
    check(result == 24'h800000, "R5 final", result, 24'h800000);

    do_restart();
    run(2, 8, "R3");
    run(3, 6, "R3");
    check(settled == 1'b1, "R6 stays", settled, 1);

    do_restart();
    run(0, 3, "R7");

    // collision of restart with the strobe edge
    for (int i = 0; i < 63; i++) send(1'($urandom), "R8");
    mod_bit = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    restart = 1'b1;
    @(posedge clk);
    clear_model();
    @(negedge clk);
    restart = 1'b0;
    check(result_valid == 1'b0 && result == '0 && settled == 1'b0, "R8",
          {result_valid, settled, result}, 0);
    run(2, 6, "R8");

    repeat (4) @(negedge clk);
    check(q_val.size() == 0, "R2 missing strobes", q_val.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    longint tmp [TAPS];
    for (int k = 0; k < TAPS; k++) h[k] = 0;
    h[0] = 1;
    for (int s = 0; s < 5; s++) begin
      for (int k = 0; k < TAPS; k++) tmp[k] = 0;
      for (int k = 0; k < TAPS; k++)
        for (int j = 0; j < 64; j++)
          if (k + j < TAPS) tmp[k+j] += h[k];
      for (int k = 0; k < TAPS; k++) h[k] = tmp[k];
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule